// File: doc/BRIEF.md
# Timer Update Event Controller

This block is the core of an up-counting timer. A prescaler divides the clock into counting ticks. A counter advances on each tick and returns to zero after it reaches the active reload limit. A compare value is checked against the counter on every cycle. The divisor, the reload limit and the compare value each have two copies. Software writes a staged copy. The logic uses an active copy, and that copy changes only when an update event occurs.

Three sources raise an update event: the counter wrapping to zero, software forcing an update through the control word, and a pulse on the slave reset input. An update pulse copies all three staged values into their active copies. An inhibit bit in the control word blocks the event and keeps the active copies as they are. A forced update or a slave reset still clears the counter and the prescaler while the inhibit bit is set. A trigger input can start the counter without a software write.

Top module: `tmr_uev_ctrl`

## Requirements
- R1: When the inhibit bit is 0, the counter wrapping from the active reload value to 0 gives a pulse on `uev_o`. The pulse appears on the same clock edge that shows the counter at 0.
- R2: A write with `wr_sel`=0 that has bit 2 set is a forced update. It clears the counter and the prescaler on the next edge and pulses `uev_o` unless that same write sets bit 1. Bit 2 is not stored.
- R3: A cycle with `slv_rst`=1 clears the counter and the prescaler on the next edge. It pulses `uev_o` when the inhibit bit is 0.
- R4: On each update pulse, the active divisor, reload and compare copies take the staged values held before that edge.
- R5: While the inhibit bit (`wr_sel`=0, bit 1) is 1, `uev_o` stays 0 and the active copies keep their values. The counter still wraps at the active reload value.
- R6: While the inhibit bit is 1, a forced update or a slave reset still clears the counter and the prescaler.
- R7: The counter and the prescaler advance only while the run bit (`wr_sel`=0, bit 0) is 1. Otherwise they hold.
- R8: A cycle with `trig_start`=1 sets the run bit on the next edge. This takes priority over a control write in the same cycle.
- R9: The counter advances once every (active divisor + 1) enabled cycles, counts 0 up to the active reload value, and then returns to 0.
- R10: Writes with `wr_sel`=1 (divisor), 2 (reload) or 3 (compare) change only the staged copies. Counting and matching behaviour is unchanged until the next update pulse.
- R11: `cmp_match_o` is 1 exactly while `cnt_o` equals the active compare value.
- R12: After reset the counter is 0, `uev_o` is 0 and the run and inhibit bits are 0. All staged and active copies are 0, so `cmp_match_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 divisor, 2 reload, 3 compare |
| wr_data | input | DATA_W | Write data |
| slv_rst | input | 1 | Slave reset / update request pulse |
| trig_start | input | 1 | Hardware start: sets the run bit |
| cnt_o | output | CNT_W | Counter value |
| uev_o | output | 1 | Update event pulse |
| cmp_match_o | output | 1 | Counter equals active compare value |

## Verification
The hardest case is a forced update or a slave reset that arrives while updates are inhibited. The counter must return to zero while the active reload and compare values stay as they were, and that is visible only through the later count period and the match flag. Directed steps first stage new values, then set the inhibit bit, and then issue both kinds of reinitialisation. After that, random runs mix control writes, staged writes, slave resets and trigger pulses against a cycle model kept in the bench. Those runs also cover an update pulse that lands on the same cycle as a staged write.

// File: rtl/tmr_uev_pkg.sv
package tmr_uev_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_LIM  = 2'd2,
      SEL_CMP  = 2'd3
   } reg_sel_e;

   localparam int CB_RUN   = 0;
   localparam int CB_HOLD  = 1;
   localparam int CB_FORCE = 2;
   localparam int CTRL_W   = 3;
endpackage

// File: rtl/tmr_shadow_reg.sv
module tmr_shadow_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stage_we,
   input  logic [W-1:0] stage_d,
   input  logic         load,
   output logic [W-1:0] stage_q,
   output logic [W-1:0] active_q
);
   if (W < 1) begin : g_bad_w
      $error("tmr_shadow_reg: W must be at least 1");
   end

   // the active copy takes the staged value held before this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         active_q <= '0;
      end else begin
         if (load)     active_q <= stage_q;
         if (stage_we) stage_q  <= stage_d;
      end
   end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reinit,
   input  logic [PSC_W-1:0] divisor,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;

   assign tick = run && (phase_q == divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (reinit) phase_q <= '0;
      else if (tick)   phase_q <= '0;
      else if (run)    phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/tmr_upcounter.sv
module tmr_upcounter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reinit,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = tick && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (reinit) cnt <= '0;
      else if (wrap)   cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tmr_uev_ctrl.sv
module tmr_uev_ctrl
   import tmr_uev_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              slv_rst,
   input  logic              trig_start,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              uev_o,
   output logic              cmp_match_o
);
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("tmr_uev_ctrl: CNT_W must not exceed DATA_W");
   end
   if (PSC_W > DATA_W) begin : g_bad_psc
      $error("tmr_uev_ctrl: PSC_W must not exceed DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("tmr_uev_ctrl: DATA_W too narrow for control word");
   end

   logic             run_q, hold_q;
   logic             ctrl_wr, force_upd, hold_eff, reinit, tick, wrap, upd;
   logic [PSC_W-1:0] div_stage, div_act;
   logic [CNT_W-1:0] lim_stage, lim_act, cmp_stage, cmp_act;

   assign ctrl_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign force_upd = ctrl_wr && wr_data[CB_FORCE];
   // an inhibit bit written in the same cycle already applies
   assign hold_eff  = ctrl_wr ? wr_data[CB_HOLD] : hold_q;
   assign reinit    = force_upd || slv_rst;
   assign upd       = (wrap || reinit) && !hold_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         hold_q <= 1'b0;
         uev_o  <= 1'b0;
      end else begin
         run_q  <= trig_start || (ctrl_wr ? wr_data[CB_RUN] : run_q);
         hold_q <= hold_eff;
         uev_o  <= upd;
      end
   end

   tmr_shadow_reg #(.W(PSC_W)) u_div (
      .clk(clk), .rst_n(rst_n),
      .stage_we(wr_en && (reg_sel_e'(wr_sel) == SEL_DIV)),
      .stage_d(wr_data[PSC_W-1:0]), .load(upd),
      .stage_q(div_stage), .active_q(div_act));

   tmr_shadow_reg #(.W(CNT_W)) u_lim (
      .clk(clk), .rst_n(rst_n),
      .stage_we(wr_en && (reg_sel_e'(wr_sel) == SEL_LIM)),
      .stage_d(wr_data[CNT_W-1:0]), .load(upd),
      .stage_q(lim_stage), .active_q(lim_act));

   tmr_shadow_reg #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .stage_we(wr_en && (reg_sel_e'(wr_sel) == SEL_CMP)),
      .stage_d(wr_data[CNT_W-1:0]), .load(upd),
      .stage_q(cmp_stage), .active_q(cmp_act));

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run_q), .reinit(reinit),
      .divisor(div_act), .tick(tick));

   tmr_upcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reinit(reinit),
      .limit(lim_act), .cnt(cnt_o), .wrap(wrap));

   assign cmp_match_o = (cnt_o == cmp_act);
endmodule

module tmr_uev_chk #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic             slv_rst,
   input logic             trig_start,
   input logic [CNT_W-1:0] cnt_o,
   input logic             uev_o,
   input logic             run_q,
   input logic             hold_q,
   input logic [PSC_W-1:0] div_act,
   input logic [CNT_W-1:0] lim_act,
   input logic [CNT_W-1:0] cmp_act,
   input logic [CNT_W-1:0] lim_stage,
   input logic [CNT_W-1:0] cmp_stage
);
   logic ctrl_wr;
   assign ctrl_wr = wr_en && (wr_sel == 2'd0);

   // R5: held inhibit blocks the event pulse
   a_r5_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !ctrl_wr) |=> !uev_o);

   // R5: held inhibit keeps active copies
   a_r5_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !ctrl_wr) |=> ($stable(lim_act) && $stable(cmp_act) && $stable(div_act)));

   // R10: active copies change only with an update pulse
   a_r10_no_direct: assert property (@(posedge clk) disable iff (!rst_n)
      !uev_o |-> ($stable(lim_act) && $stable(cmp_act)));

   // R4: update copies staged values
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      uev_o |-> (lim_act == $past(lim_stage) && cmp_act == $past(cmp_stage)));

   // R3 / R6: slave reset clears the counter
   a_r6_slave_clear: assert property (@(posedge clk) disable iff (!rst_n)
      slv_rst |=> (cnt_o == '0));

   // R7: stopped counter holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !slv_rst && !ctrl_wr) |=> $stable(cnt_o));

   // R8: trigger starts the counter
   a_r8_trig: assert property (@(posedge clk) disable iff (!rst_n)
      trig_start |=> run_q);
endmodule

bind tmr_uev_ctrl tmr_uev_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .slv_rst(slv_rst), .trig_start(trig_start), .cnt_o(cnt_o), .uev_o(uev_o),
   .run_q(run_q), .hold_q(hold_q), .div_act(div_act), .lim_act(lim_act),
   .cmp_act(cmp_act), .lim_stage(lim_stage), .cmp_stage(cmp_stage));

// File: tb/sim_tmr_uev_ctrl.sv
module sim_tmr_uev_ctrl;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [DW-1:0] wr_data = '0;
   logic          slv_rst = 1'b0;
   logic          trig_start = 1'b0;
   logic [15:0]   cnt_o;
   logic          uev_o, cmp_match_o;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   logic        m_run = 0, m_hold = 0, m_uev = 0;
   logic [15:0] m_stage [3];
   logic [15:0] m_act   [3];
   logic [15:0] m_ph = 0, m_cnt = 0;

   always #5 clk = ~clk;

   tmr_uev_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .slv_rst(slv_rst), .trig_start(trig_start), .cnt_o(cnt_o), .uev_o(uev_o),
      .cmp_match_o(cmp_match_o));

   task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // index 0 divisor, 1 reload, 2 compare
   task automatic step(input logic we, input logic [1:0] sel, input logic [15:0] d,
                       input logic sr, input logic tr, input string tag);
      logic cw, fu, he, ri, tk, wp, ev;
      wr_en = we; wr_sel = sel; wr_data = d; slv_rst = sr; trig_start = tr;
      @(posedge clk);
      cw = we && sel == 2'd0;
      fu = cw && d[2];
      he = cw ? d[1] : m_hold;
      ri = fu || sr;
      tk = m_run && (m_ph == m_act[0]);
      wp = tk && (m_cnt == m_act[1]);
      ev = (wp || ri) && !he;
      if (ri || tk)    m_ph = 0;
      else if (m_run)  m_ph = m_ph + 1;
      if (ri || wp)    m_cnt = 0;
      else if (tk)     m_cnt = m_cnt + 1;
      if (ev) for (int i = 0; i < 3; i++) m_act[i] = m_stage[i];
      if (we && sel != 2'd0) m_stage[sel - 1] = d;
      m_run  = tr || (cw ? d[0] : m_run);
      m_hold = he;
      m_uev  = ev;
      @(negedge clk);
      wr_en = 0; slv_rst = 0; trig_start = 0;
      check(tag, "cnt_o", cnt_o, m_cnt);
      check(tag, "uev_o", {15'd0, uev_o}, {15'd0, m_uev});
      check({tag, "/R11"}, "cmp_match_o", {15'd0, cmp_match_o}, {15'd0, m_cnt == m_act[2]});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2417));
      for (int i = 0; i < 3; i++) begin m_stage[i] = 0; m_act[i] = 0; end
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", "cnt_o", cnt_o, 0);
      check("R12", "uev_o", {15'd0, uev_o}, 0);
      check("R12", "cmp_match_o", {15'd0, cmp_match_o}, 1);
      rst_n = 1'b1;
      idle(2, "R12");
      // R10: staged writes leave counting untouched
      step(1, 1, 16'd1, 0, 0, "R10");
      step(1, 2, 16'd3, 0, 0, "R10");
      step(1, 3, 16'd2, 0, 0, "R10");
      step(1, 0, 16'h1, 0, 0, "R7");
      idle(3, "R10");
      // R2 forced update loads staged values
      step(1, 0, 16'h5, 0, 0, "R2");
      idle(20, "R9");
      step(0, 0, 0, 1, 0, "R3");
      idle(5, "R1");
      // R5: inhibit, stage a new reload
      step(1, 0, 16'h3, 0, 0, "R5");
      step(1, 2, 16'd5, 0, 0, "R5");
      idle(20, "R5");
      step(1, 0, 16'h7, 0, 0, "R6");
      idle(3, "R6");
      step(0, 0, 0, 1, 0, "R6");
      idle(3, "R6");
      // R7 stop, R8 trigger start
      step(1, 0, 16'h0, 0, 0, "R7");
      idle(5, "R7");
      step(0, 0, 0, 0, 1, "R8");
      idle(6, "R8");
      step(1, 0, 16'h5, 0, 1, "R4");
      idle(15, "R4");
      // random mix
      for (int k = 0; k < 3000; k++) begin
         int r;
         logic we; logic [1:0] sel; logic [15:0] d;
         r = $urandom_range(0, 99);
         we = (r < 12); sel = 2'($urandom_range(0, 3));
         if (sel == 0) d = 16'($urandom_range(0, 7) | (($urandom_range(0, 3) == 0) ? 0 : 1));
         else if (sel == 1) d = 16'($urandom_range(0, 3));
         else d = 16'($urandom_range(0, 9));
         if (sel == 0 && $urandom_range(0, 2) != 0) d[1] = 1'b0;
         step(we, sel, d, $urandom_range(0, 60) == 0, $urandom_range(0, 80) == 0, "R9");
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule